// File: doc/BRIEF.md
# Dual-Phase Offset Chopper Controller

This block sequences the gate enables of two H-bridges that drive the two windings of a bipolar stepper motor. Each bridge receives a direction bit and a two-bit current code from the control side, plus a comparator flag that rises when the winding current crosses its sense threshold. From these inputs the block decides which diagonal pair of transistors conducts. When the threshold is crossed, the block switches off only the low-side (sink) device and leaves the high-side device on. The current then freewheels and decays slowly until an oscillator tick switches the sink device back on.

The two bridges are re-armed on opposite extremes of a shared oscillator: bridge A on the maximum tick and bridge B on the minimum tick. Their turn-on instants are therefore interleaved, which keeps each step in supply current to half the size it would otherwise have. After every sink turn-on, a blanking window masks the comparator so that switching spikes are not taken as a threshold crossing. When the direction of a conducting bridge is reversed, both diagonals are held off for a dead-time before the opposite pair is enabled. While both diagonals are off the current decays fast.

Top module: `dual_chopper_ctrl`

## Requirements
- R1: While `rst_n` is low, both gate vectors are 4'b0000 whatever the other inputs are.
- R2: A current code of 2'b11 on a bridge makes its gate vector 4'b0000 from the next clock edge on, whatever its comparator flag says, and leaves the other bridge unchanged.
- R3: Gate vector bits are: bit 3 high-side of output 1, bit 2 high-side of output 2, bit 1 low-side of output 1, bit 0 low-side of output 2. From the off state, a code of 2'b00, 2'b01 or 2'b10 gives 4'b1001 one edge later when the direction bit is 1, and 4'b0110 when it is 0.
- R4: A comparator flag sampled while the sink is on and no blanking is pending turns off only the sink at that edge, giving 4'b1000 (direction 1) or 4'b0100 (direction 0).
- R5: A chopped sink stays off until the bridge's own oscillator tick arrives: `osc_max_tick` for bridge A and `osc_min_tick` for bridge B. The other bridge's tick, or no tick at all, keeps it off. Its own tick turns the sink back on at the next edge.
- R6: After every sink turn-on (first turn-on, tick re-enable, or the end of a reversal), the comparator flag is ignored at the next `BLANK_CYC` clock edges and takes effect at the edge after those.
- R7: When a bridge's tick and its comparator flag are both high at the same edge, the tick wins and the sink turns on.
- R8: A change of direction bit while a bridge is conducting gives 4'b0000 for exactly `DEAD_CYC` clock cycles, then the opposite diagonal with its sink on and blanking restarted.
- R9: High-side and low-side of the same output are never both on, and one high-side never follows the other in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cur_a | input | 2 | Bridge A current code, 2'b11 = off |
| pol_a | input | 1 | Bridge A direction, 1 = output 1 high |
| trip_a | input | 1 | Bridge A comparator flag, threshold crossed |
| cur_b | input | 2 | Bridge B current code, 2'b11 = off |
| pol_b | input | 1 | Bridge B direction, 1 = output 1 high |
| trip_b | input | 1 | Bridge B comparator flag, threshold crossed |
| osc_max_tick | input | 1 | One-cycle pulse at the oscillator maximum, re-arms bridge A |
| osc_min_tick | input | 1 | One-cycle pulse at the oscillator minimum, re-arms bridge B |
| gate_a | output | 4 | Bridge A gate enables {hs1, hs2, ls1, ls2} |
| gate_b | output | 4 | Bridge B gate enables {hs1, hs2, ls1, ls2} |

## Verification
The hold property for a chopped sink relies on the direction bit still matching the conducting diagonal and the code staying away from 2'b11. It is therefore written with those conditions in its antecedent, and the stimulus changes direction or code only in dedicated scenarios. The checker also assumes that the inputs are synchronous to `clk` and that the oscillator ticks are single-cycle pulses. The bench drives every input on the falling edge and raises each tick for exactly one cycle. It never pulses both ticks at once, so the effect of each tick on its own bridge can be told apart from its effect on the other.

// File: rtl/chop_pkg.sv
package chop_pkg;
  localparam int NUM_BRIDGES = 2;
  localparam int BR_A = 0;
  localparam int BR_B = 1;

  // current code that removes all drive from a bridge
  localparam logic [1:0] CUR_ZERO = 2'b11;

  // bit positions inside a gate vector
  localparam int G_HS1 = 3;
  localparam int G_HS2 = 2;
  localparam int G_LS1 = 1;
  localparam int G_LS2 = 0;

  typedef logic [3:0] gate_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DEAD  = 2'd1,
    ST_DRIVE = 2'd2
  } leg_state_e;
endpackage

// File: rtl/chop_span_timer.sv
// Down-counter that stays busy for LOAD_VAL cycles after a load pulse.
module chop_span_timer #(
  parameter int W        = 4,
  parameter int LOAD_VAL = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    if (load) cnt_d = LOAD_VAL[W-1:0];
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/chop_bridge_seq.sv
// Gate sequencer for one H-bridge: diagonal select, sink chopping,
// blanking after sink turn-on and dead-time on direction reversal.
module chop_bridge_seq
  import chop_pkg::*;
#(
  parameter int BLANK_CYC = 12,
  parameter int DEAD_CYC  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cur_code,
  input  logic       pol,
  input  logic       trip,
  input  logic       rearm,
  output gate_t      gate
);
  localparam int BLANK_W = (BLANK_CYC > 0) ? $clog2(BLANK_CYC + 1) : 1;
  localparam int DEAD_W  = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam int DEAD_LD = (DEAD_CYC > 0) ? DEAD_CYC - 1 : 0;

  leg_state_e state_q, state_d;
  logic       act_pol_q, act_pol_d;
  logic       chop_q, chop_d;
  logic       blank_load, dead_load;
  logic       blank_busy, dead_busy;
  logic       drive_req, trip_ok;

  chop_span_timer #(.W(BLANK_W), .LOAD_VAL(BLANK_CYC)) u_blank (
    .clk  (clk),
    .rst_n(rst_n),
    .load (blank_load),
    .busy (blank_busy)
  );

  chop_span_timer #(.W(DEAD_W), .LOAD_VAL(DEAD_LD)) u_dead (
    .clk  (clk),
    .rst_n(rst_n),
    .load (dead_load),
    .busy (dead_busy)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    act_pol_d  = act_pol_q;
    chop_d     = chop_q;
    blank_load = 1'b0;
    dead_load  = 1'b0;
    drive_req  = (cur_code != CUR_ZERO);
    trip_ok    = (state_q == ST_DRIVE) && !chop_q && !blank_busy && trip;

    case (state_q)
      ST_IDLE: begin
        chop_d = 1'b0;
        if (drive_req) begin
          state_d    = ST_DRIVE;
          act_pol_d  = pol;
          blank_load = 1'b1;
        end
      end
      ST_DEAD: begin
        chop_d = 1'b0;
        if (!drive_req) begin
          state_d = ST_IDLE;
        end else if (!dead_busy) begin
          state_d    = ST_DRIVE;
          act_pol_d  = pol;
          blank_load = 1'b1;
        end
      end
      ST_DRIVE: begin
        if (!drive_req) begin
          state_d = ST_IDLE;
          chop_d  = 1'b0;
        end else if (pol != act_pol_q) begin
          state_d   = ST_DEAD;
          dead_load = 1'b1;
          chop_d    = 1'b0;
        end else if (rearm) begin
          // reset-dominant latch: the tick beats a simultaneous trip
          chop_d     = 1'b0;
          blank_load = chop_q;
        end else if (trip_ok) begin
          chop_d = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        chop_d  = 1'b0;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      act_pol_q <= 1'b0;
      chop_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      act_pol_q <= act_pol_d;
      chop_q    <= chop_d;
    end
  end

  // gate decode from registered state only
  always_comb begin
    gate = '0;
    if (state_q == ST_DRIVE) begin
      gate[G_HS1] = act_pol_q;
      gate[G_HS2] = !act_pol_q;
      gate[G_LS2] = act_pol_q & !chop_q;
      gate[G_LS1] = !act_pol_q & !chop_q;
    end
  end
endmodule

// File: rtl/dual_chopper_ctrl.sv
// Two bridge sequencers re-armed on opposite oscillator extremes.
module dual_chopper_ctrl
  import chop_pkg::*;
#(
  parameter int BLANK_CYC = 12,
  parameter int DEAD_CYC  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cur_a,
  input  logic       pol_a,
  input  logic       trip_a,
  input  logic [1:0] cur_b,
  input  logic       pol_b,
  input  logic       trip_b,
  input  logic       osc_max_tick,
  input  logic       osc_min_tick,
  output logic [3:0] gate_a,
  output logic [3:0] gate_b
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic [NUM_BRIDGES-1:0][1:0] cur_v;
  logic [NUM_BRIDGES-1:0]      pol_v;
  logic [NUM_BRIDGES-1:0]      trip_v;
  logic [NUM_BRIDGES-1:0]      tick_v;
  gate_t [NUM_BRIDGES-1:0]     gate_v;

  assign cur_v[BR_A]  = cur_a;
  assign cur_v[BR_B]  = cur_b;
  assign pol_v[BR_A]  = pol_a;
  assign pol_v[BR_B]  = pol_b;
  assign trip_v[BR_A] = trip_a;
  assign trip_v[BR_B] = trip_b;
  // offset chopping: A on the maximum, B on the minimum
  assign tick_v[BR_A] = osc_max_tick;
  assign tick_v[BR_B] = osc_min_tick;

  for (genvar g = 0; g < NUM_BRIDGES; g++) begin : g_bridge
    chop_bridge_seq #(
      .BLANK_CYC(BLANK_CYC),
      .DEAD_CYC (DEAD_CYC)
    ) u_seq (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .cur_code(cur_v[g]),
      .pol     (pol_v[g]),
      .trip    (trip_v[g]),
      .rearm   (tick_v[g]),
      .gate    (gate_v[g])
    );
  end

  assign gate_a = gate_v[BR_A];
  assign gate_b = gate_v[BR_B];
endmodule

// File: rtl/dual_chopper_chk.sv
module dual_chopper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cur_a,
  input logic       pol_a,
  input logic [1:0] cur_b,
  input logic       pol_b,
  input logic       osc_max_tick,
  input logic       osc_min_tick,
  input logic [3:0] gate_a,
  input logic [3:0] gate_b
);
  assert_zero_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_a == 2'b11) |=> (gate_a == 4'b0000));
  assert_zero_code_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_b == 2'b11) |=> (gate_b == 4'b0000));

  assert_no_shoot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_a[3] && gate_a[1]) && !(gate_a[2] && gate_a[0]) &&
    !(gate_b[3] && gate_b[1]) && !(gate_b[2] && gate_b[0]));

  assert_bbm_hs1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_a[3] || gate_b[3]) |=> !((gate_a[2] && $past(gate_a[3])) ||
                                   (gate_b[2] && $past(gate_b[3]))));
  assert_bbm_hs2_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_a[2] || gate_b[2]) |=> !((gate_a[3] && $past(gate_a[2])) ||
                                   (gate_b[3] && $past(gate_b[2]))));

  assert_hold_a1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_a == 4'b1000 && !osc_max_tick && cur_a != 2'b11 && pol_a)
    |=> (gate_a == 4'b1000));
  assert_hold_a0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_a == 4'b0100 && !osc_max_tick && cur_a != 2'b11 && !pol_a)
    |=> (gate_a == 4'b0100));
  assert_hold_b0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_b == 4'b0100 && !osc_min_tick && cur_b != 2'b11 && !pol_b)
    |=> (gate_b == 4'b0100));
  assert_hold_b1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_b == 4'b1000 && !osc_min_tick && cur_b != 2'b11 && pol_b)
    |=> (gate_b == 4'b1000));
endmodule

bind dual_chopper_ctrl dual_chopper_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cur_a       (cur_a),
  .pol_a       (pol_a),
  .cur_b       (cur_b),
  .pol_b       (pol_b),
  .osc_max_tick(osc_max_tick),
  .osc_min_tick(osc_min_tick),
  .gate_a      (gate_a),
  .gate_b      (gate_b)
);

// File: tb/dual_chopper_ctrl_bench.sv
`timescale 1ns/1ps
module dual_chopper_ctrl_bench;
  localparam int BLANK = 12;
  localparam int DEAD  = 8;

  logic       clk;
  logic       rst_n;
  logic [1:0] cur_a, cur_b;
  logic       pol_a, pol_b, trip_a, trip_b;
  logic       osc_max_tick, osc_min_tick;
  logic [3:0] gate_a, gate_b;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;

  dual_chopper_ctrl #(.BLANK_CYC(BLANK), .DEAD_CYC(DEAD)) u_dual_chopper_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cur_a(cur_a), .pol_a(pol_a), .trip_a(trip_a),
    .cur_b(cur_b), .pol_b(pol_b), .trip_b(trip_b),
    .osc_max_tick(osc_max_tick), .osc_min_tick(osc_min_tick),
    .gate_a(gate_a), .gate_b(gate_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cur_a = 2'b00; pol_a = 1'b1; trip_a = 1'b0;
    cur_b = 2'b01; pol_b = 1'b0; trip_b = 1'b0;
    osc_max_tick = 1'b0; osc_min_tick = 1'b0;
    step();
    chk("R1 gate_a in reset", gate_a, 4'b0000);
    step();
    chk("R1 gate_b in reset", gate_b, 4'b0000);
    cur_a = 2'b11; cur_b = 2'b11;
    rst_n = 1'b1;
    repeat (5) step();
    chk("R1 gate_a after release", gate_a, 4'b0000);
  endtask

  task automatic t_turn_on();
    cur_a = 2'b00; pol_a = 1'b1;
    cur_b = 2'b01; pol_b = 1'b0;
    step();
    chk("R3 bridge A dir 1", gate_a, 4'b1001);
    chk("R3 bridge B dir 0", gate_b, 4'b0110);
    repeat (20) step();
  endtask

  task automatic t_code_off();
    cur_a = 2'b11; trip_a = 1'b1;
    step();
    chk("R2 code 11 off", gate_a, 4'b0000);
    chk("R2 other bridge kept", gate_b, 4'b0110);
    trip_a = 1'b0;
    repeat (3) step();
    chk("R2 stays off", gate_a, 4'b0000);
  endtask

  task automatic t_blank_turn_on();
    cur_a = 2'b10; pol_a = 1'b1; trip_a = 1'b1;
    for (int k = 0; k <= BLANK; k++) begin
      step();
      chk("R6 trip blanked after turn-on", gate_a, 4'b1001);
    end
    step();
    chk("R4 sink off only", gate_a, 4'b1000);
    trip_a = 1'b0;
  endtask

  task automatic t_chop_hold();
    osc_min_tick = 1'b1; step(); osc_min_tick = 1'b0;
    chk("R5 other tick ignored", gate_a, 4'b1000);
    repeat (20) step();
    chk("R5 no tick stays off", gate_a, 4'b1000);
    trip_b = 1'b1; step(); trip_b = 1'b0;
    chk("R4 bridge B sink off", gate_b, 4'b0100);
    osc_max_tick = 1'b1; step(); osc_max_tick = 1'b0;
    chk("R5 max tick re-arms A", gate_a, 4'b1001);
    chk("R5 max tick leaves B", gate_b, 4'b0100);
    osc_min_tick = 1'b1; step(); osc_min_tick = 1'b0;
    chk("R5 min tick re-arms B", gate_b, 4'b0110);
  endtask

  task automatic t_rearm_blank();
    repeat (20) step();
    trip_a = 1'b1; step();
    chk("R4 chop before re-arm", gate_a, 4'b1000);
    osc_max_tick = 1'b1; step(); osc_max_tick = 1'b0;
    chk("R7 tick beats trip", gate_a, 4'b1001);
    for (int k = 0; k < BLANK; k++) begin
      step();
      chk("R6 trip blanked after re-arm", gate_a, 4'b1001);
    end
    step();
    chk("R6 trip taken after blanking", gate_a, 4'b1000);
    trip_a = 1'b0;
    osc_max_tick = 1'b1; step(); osc_max_tick = 1'b0;
    chk("R5 restore", gate_a, 4'b1001);
  endtask

  task automatic t_reverse();
    repeat (20) step();
    pol_a = 1'b0;
    for (int k = 0; k < DEAD; k++) begin
      step();
      chk((k == 0) ? "R9 no overlap at reversal" : "R8 dead time", gate_a, 4'b0000);
    end
    step();
    chk("R8 opposite pair on", gate_a, 4'b0110);
    trip_a = 1'b1;
    for (int k = 0; k < BLANK; k++) begin
      step();
      chk("R8 blanking after reversal", gate_a, 4'b0110);
    end
    step();
    chk("R8 sink chop after reversal", gate_a, 4'b0100);
    trip_a = 1'b0;
  endtask

  initial begin
    t_reset();
    t_turn_on();
    t_code_off();
    t_blank_turn_on();
    t_chop_hold();
    t_rearm_blank();
    t_reverse();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule